// File: doc/BRIEF.md
# Guest Segment Access-Rights Checker

This block decides whether the saved state of one guest segment register is fit to load before a guest is entered. For each request it takes the register kind, the 16-bit selector, the 32-bit limit, the 32-bit access-rights word and the 64-bit base. It also takes two mode flags, one for a virtual-8086 guest and one for a 64-bit-mode guest, and the RPL of the guest code selector. The verdict arrives on the clock edge after the request. It is a 16-bit vector with one bit per rule group, plus a pass flag.

The rules change with the register kind, the guest mode and the unusable flag (access-rights bit 16). A stack, data or local-table register that is marked unusable skips the rules that only make sense for a usable register. The code and task registers are always checked in full. The granularity bit is checked against the limit. The privilege fields are compared with each other and with the supplied code RPL. Each request carries every input it needs, so requests can be issued back to back, one per clock.

Control is a two-state machine. In ST_IDLE no result is valid. The transition GO_REPORT is taken on a clock edge with `in_valid` high and leads to ST_REPORT, where `out_valid` is high. STAY_REPORT keeps ST_REPORT while requests keep arriving. GO_IDLE returns to ST_IDLE on an edge with `in_valid` low. The result registers hold their last value whenever no request arrives.

Top module: `seg_access_checker`

## Requirements
- R1: After reset, out_valid, out_pass and out_fail are all 0.
- R2: A request sampled with in_valid high moves the machine to ST_REPORT, so out_valid is 1 after that edge and out_fail/out_pass show that request's verdict. An edge with in_valid low returns the machine to ST_IDLE, so out_valid is 0. While in_valid is low, out_fail and out_pass keep their values whatever the other inputs do.
- R3: out_pass is 1 exactly when every bit of out_fail is 0.
- R4: The in_kind codes are 0 code, 1 stack, 2 data, 3 data with a 64-bit base (FS/GS), 4 task and 5 local descriptor table. Codes 6 and 7 give out_fail = 16'h8000, with bit 15 set and no other bit.
- R5: Fail bit 0 is set when a task register has access-rights bit 16 (unusable) set, or when a virtual-8086 guest has bit 16 set on a code, stack or data register. An unusable stack, data or local-table register is exempt from every rule this list marks "when usable".
- R6: Fail bit 1 flags the type field, access-rights bits 3:0. Task: type 11 in 64-bit mode, otherwise 3 or 11. Local table when usable: type 2. Code: bit 0 set; outside virtual-8086 bit 3 set; in virtual-8086 type 3. Stack: type 3 or 7 when usable; type 3 in virtual-8086. Data (both kinds): when usable, bit 0 set, and bit 1 set if bit 3 is set; type 3 in virtual-8086.
- R7: Fail bit 2 flags the descriptor-type bit, access-rights bit 4. It must be 0 for task and for usable local table, and 1 for code and for usable stack and data.
- R8: Fail bit 3 flags the DPL, bits 6:5, against the selector RPL, bits 1:0. Code with type 8–11 needs DPL equal to RPL, and code with type 13–15 needs DPL not above RPL. Stack outside virtual-8086 needs DPL equal to RPL. Usable data outside virtual-8086 with type 0–11 needs DPL not below RPL. Code, stack and data in virtual-8086 need DPL 3. Fail bit 10 is set when a stack register outside virtual-8086 has an RPL different from in_cs_rpl.
- R9: Fail bit 4 flags the present bit, bit 7, which must be 1. Fail bit 5 flags bits 11:8, which must be 0. Both apply to code and task always, and to the other kinds when usable. Fail bit 8 flags bits 31:17, which must be 0 for code and task.
- R10: Fail bit 6 is set when bit 14 (D/B) is 1 on a code register that is in virtual-8086, or in 64-bit mode with bit 13 set. It is also set when D/B is 1 on a stack or data register in virtual-8086.
- R11: Fail bit 7 flags bit 15 (G). G must be 0 when any of limit bits 11:0 is 0 or the guest is virtual-8086, and G must be 1 when any of limit bits 31:20 is 1. This applies to code and task always, and to the other kinds when usable.
- R12: In virtual-8086, for code, stack and data kinds: fail bit 11 is set when the base differs from the selector shifted left by 4, and fail bit 12 is set when the limit differs from 32'h0000FFFF.
- R13: Fail bit 9 flags selector bit 2 set, on task or on usable local table. Fail bit 13 flags a non-canonical base (bits 63:47 not all equal) on task, usable local table or data-with-64-bit-base. Fail bit 14 flags a nonzero base bits 63:32 on code, and on usable stack or plain data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_kind | input | 3 | Register kind code |
| in_sel | input | 16 | Segment selector |
| in_limit | input | 32 | Segment limit |
| in_ar | input | 32 | Access-rights word |
| in_base | input | 64 | Segment base address |
| in_v86 | input | 1 | Guest will run in virtual-8086 mode |
| in_lm | input | 1 | Guest will run in 64-bit mode |
| in_cs_rpl | input | 2 | RPL of the guest code selector |
| out_valid | output | 1 | Verdict valid (machine in ST_REPORT) |
| out_pass | output | 1 | All rules held |
| out_fail | output | 16 | One bit per violated rule group |

## Verification
The bench builds the block with its default widths: a 16-bit selector, a 32-bit limit, a 64-bit base and a 48-bit canonical span. It then issues 32768 back-to-back requests. These cover every kind code (the two illegal ones included), all four mode pairs, all 16 type values and every combination of the S, present, unusable, DPL and G bits. The selector RPL and TI bit, the L and D/B bits, the reserved bits and the code RPL vary from request to request. Limits are drawn from a set that straddles the granularity rules. Bases are drawn from a set that holds a virtual-8086-consistent value, canonical and non-canonical values, and a value with high bits set. This brings every rule group, and most pairs of them, within reach under the default configuration.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

    localparam int FAIL_W = 16;

    typedef enum logic [2:0] {
        KIND_CODE   = 3'd0,
        KIND_STACK  = 3'd1,
        KIND_DATA   = 3'd2,
        KIND_DATA64 = 3'd3,
        KIND_TASK   = 3'd4,
        KIND_LDT    = 3'd5
    } seg_kind_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } chk_state_e;

    // access-rights field positions
    localparam int AR_S    = 4;
    localparam int AR_P    = 7;
    localparam int AR_L    = 13;
    localparam int AR_DB   = 14;
    localparam int AR_G    = 15;
    localparam int AR_UNUS = 16;

    // failure vector bit positions
    localparam int FB_UNUSABLE = 0;
    localparam int FB_TYPE     = 1;
    localparam int FB_SBIT     = 2;
    localparam int FB_DPL      = 3;
    localparam int FB_PRESENT  = 4;
    localparam int FB_RSVD_LO  = 5;
    localparam int FB_DB       = 6;
    localparam int FB_GRAN     = 7;
    localparam int FB_RSVD_HI  = 8;
    localparam int FB_SEL_TI   = 9;
    localparam int FB_SS_RPL   = 10;
    localparam int FB_V86_BASE = 11;
    localparam int FB_V86_LIM  = 12;
    localparam int FB_CANON    = 13;
    localparam int FB_BASE_HI  = 14;
    localparam int FB_KIND     = 15;

endpackage

// File: rtl/seg_ar_rules.sv
module seg_ar_rules
    import seg_chk_pkg::*;
#(
    parameter int LIM_W = 32
) (
    input  logic [2:0]        kind,
    input  logic [11:0]       ar_lo,
    input  logic [31:13]      ar_hi,
    input  logic [1:0]        rpl,
    input  logic [11:0]       lim_low,
    input  logic [LIM_W-1:20] lim_high,
    input  logic              v86,
    input  logic              lm,
    output logic [FAIL_W-1:0] fail_part
);

    logic is_code, is_stack, is_data, is_task, is_ldt, usable;
    logic [3:0] typ;
    logic [1:0] dpl;
    logic       chk_full;

    assign is_code  = (kind == KIND_CODE);
    assign is_stack = (kind == KIND_STACK);
    assign is_data  = (kind == KIND_DATA) || (kind == KIND_DATA64);
    assign is_task  = (kind == KIND_TASK);
    assign is_ldt   = (kind == KIND_LDT);
    assign usable   = ~ar_hi[AR_UNUS];
    assign typ      = ar_lo[3:0];
    assign dpl      = ar_lo[6:5];
    assign chk_full = is_code || is_task || ((is_stack || is_data || is_ldt) && usable);

    always_comb begin
        fail_part = '0;

        fail_part[FB_UNUSABLE] = (is_task && !usable)
                              || (v86 && (is_code || is_stack || is_data) && !usable);

        fail_part[FB_TYPE] =
              (is_task  && (lm ? (typ != 4'd11) : !((typ == 4'd3) || (typ == 4'd11))))
           || (is_ldt   && usable && (typ != 4'd2))
           || (is_code  && (!typ[0] || (!v86 && !typ[3]) || (v86 && typ != 4'd3)))
           || (is_stack && ((usable && !((typ == 4'd3) || (typ == 4'd7))) || (v86 && typ != 4'd3)))
           || (is_data  && ((usable && !typ[0]) || (usable && typ[3] && !typ[1])
                            || (v86 && typ != 4'd3)));

        fail_part[FB_SBIT] = (is_task && ar_lo[AR_S])
                          || (is_ldt && usable && ar_lo[AR_S])
                          || (is_code && !ar_lo[AR_S])
                          || ((is_stack || is_data) && usable && !ar_lo[AR_S]);

        fail_part[FB_DPL] =
              (is_code  && (typ >= 4'd8) && (typ <= 4'd11) && (dpl != rpl))
           || (is_code  && (typ >= 4'd13) && (dpl > rpl))
           || (is_stack && !v86 && (dpl != rpl))
           || (is_data  && !v86 && usable && (typ <= 4'd11) && (dpl < rpl))
           || ((is_code || is_stack || is_data) && v86 && (dpl != 2'd3));

        fail_part[FB_PRESENT] = chk_full && !ar_lo[AR_P];
        fail_part[FB_RSVD_LO] = chk_full && (ar_lo[11:8] != 4'd0);
        fail_part[FB_RSVD_HI] = (is_code || is_task) && (ar_hi[31:17] != '0);

        fail_part[FB_DB] = (is_code && ar_hi[AR_DB] && (v86 || (lm && ar_hi[AR_L])))
                        || ((is_stack || is_data) && v86 && ar_hi[AR_DB]);

        fail_part[FB_GRAN] = chk_full &&
            ((ar_hi[AR_G] && ((lim_low != 12'hFFF) || v86))
             || (!ar_hi[AR_G] && (lim_high != '0)));
    end

endmodule

// File: rtl/seg_addr_rules.sv
module seg_addr_rules
    import seg_chk_pkg::*;
#(
    parameter int SEL_W  = 16,
    parameter int LIM_W  = 32,
    parameter int BASE_W = 64,
    parameter int VA_W   = 48
) (
    input  logic [2:0]        kind,
    input  logic [SEL_W-1:0]  sel,
    input  logic [LIM_W-1:0]  limit,
    input  logic [BASE_W-1:0] base,
    input  logic              unusable,
    input  logic              v86,
    input  logic [1:0]        cs_rpl,
    output logic [FAIL_W-1:0] fail_part
);

    localparam int PAD_W = BASE_W - SEL_W - 4;
    localparam logic [LIM_W-1:0] V86_LIMIT = LIM_W'(32'h0000_FFFF);

    logic is_code, is_stack, is_plain, is_d64, is_task, is_ldt, usable, v86_kind;
    logic canon_ok;
    logic [BASE_W-1:0] v86_base;

    assign is_code  = (kind == KIND_CODE);
    assign is_stack = (kind == KIND_STACK);
    assign is_plain = (kind == KIND_DATA);
    assign is_d64   = (kind == KIND_DATA64);
    assign is_task  = (kind == KIND_TASK);
    assign is_ldt   = (kind == KIND_LDT);
    assign usable   = ~unusable;
    assign v86_kind = v86 && (is_code || is_stack || is_plain || is_d64);
    assign v86_base = {{PAD_W{1'b0}}, sel, 4'b0000};

    generate
        if (VA_W < BASE_W) begin : g_canon
            logic [BASE_W-VA_W:0] top_bits;
            assign top_bits = base[BASE_W-1:VA_W-1];
            assign canon_ok = (&top_bits) || (top_bits == '0);
        end else begin : g_flat
            assign canon_ok = 1'b1;
        end
    endgenerate

    always_comb begin
        fail_part = '0;
        fail_part[FB_SEL_TI]   = (is_task || (is_ldt && usable)) && sel[2];
        fail_part[FB_SS_RPL]   = is_stack && !v86 && (sel[1:0] != cs_rpl);
        fail_part[FB_V86_BASE] = v86_kind && (base != v86_base);
        fail_part[FB_V86_LIM]  = v86_kind && (limit != V86_LIMIT);
        fail_part[FB_CANON]    = (is_task || (is_ldt && usable) || is_d64) && !canon_ok;
        fail_part[FB_BASE_HI]  = (is_code || ((is_stack || is_plain) && usable))
                              && (base[BASE_W-1:32] != '0);
    end

endmodule

// File: rtl/seg_access_checker.sv
module seg_access_checker
    import seg_chk_pkg::*;
#(
    parameter int SEL_W  = 16,
    parameter int LIM_W  = 32,
    parameter int BASE_W = 64,
    parameter int VA_W   = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_kind,
    input  logic [SEL_W-1:0]  in_sel,
    input  logic [LIM_W-1:0]  in_limit,
    input  logic [31:0]       in_ar,
    input  logic [BASE_W-1:0] in_base,
    input  logic              in_v86,
    input  logic              in_lm,
    input  logic [1:0]        in_cs_rpl,
    output logic              out_valid,
    output logic              out_pass,
    output logic [FAIL_W-1:0] out_fail
);

    chk_state_e        state, state_nx;
    logic [FAIL_W-1:0] ar_fail, addr_fail, fail_vec;
    logic              ar_avail_unused;
    logic              kind_bad;

    assign ar_avail_unused = in_ar[12];
    assign kind_bad        = (in_kind > 3'd5);

    seg_ar_rules #(.LIM_W(LIM_W)) u_ar_rules (
        .kind      (in_kind),
        .ar_lo     (in_ar[11:0]),
        .ar_hi     (in_ar[31:13]),
        .rpl       (in_sel[1:0]),
        .lim_low   (in_limit[11:0]),
        .lim_high  (in_limit[LIM_W-1:20]),
        .v86       (in_v86),
        .lm        (in_lm),
        .fail_part (ar_fail)
    );

    seg_addr_rules #(
        .SEL_W (SEL_W), .LIM_W (LIM_W), .BASE_W (BASE_W), .VA_W (VA_W)
    ) u_addr_rules (
        .kind      (in_kind),
        .sel       (in_sel),
        .limit     (in_limit),
        .base      (in_base),
        .unusable  (in_ar[AR_UNUS]),
        .v86       (in_v86),
        .cs_rpl    (in_cs_rpl),
        .fail_part (addr_fail)
    );

    always_comb begin
        fail_vec = ar_fail | addr_fail;
        fail_vec[FB_KIND] = kind_bad;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (in_valid)  state_nx = ST_REPORT;
            ST_REPORT: if (!in_valid) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_fail <= '0;
            out_pass <= 1'b0;
        end else if (in_valid) begin
            out_fail <= fail_vec;
            out_pass <= ~|fail_vec;
        end
    end

    assign out_valid = (state == ST_REPORT);

endmodule

// File: rtl/seg_access_checker_sva.sv
module seg_access_checker_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [2:0]  in_kind,
    input logic        tr_unusable,
    input logic [31:0] in_limit,
    input logic        in_v86,
    input logic        out_valid,
    input logic        out_pass,
    input logic [15:0] out_fail
);

    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                            // R2
    AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                          // R2
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_fail) && $stable(out_pass)));            // R2
    AST_PASS_IS_NOR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_pass == (out_fail == 16'h0000)));                // R3
    AST_BAD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind > 3'd5) |=> (out_fail == 16'h8000));           // R4
    AST_TASK_USABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 3'd4 && tr_unusable) |=> out_fail[0]);      // R5
    AST_V86_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_v86 && in_kind <= 3'd3 && in_limit != 32'h0000FFFF)
        |=> out_fail[12]);                                                  // R12

endmodule

bind seg_access_checker seg_access_checker_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_kind     (in_kind),
    .tr_unusable (in_ar[16]),
    .in_limit    (in_limit),
    .in_v86      (in_v86),
    .out_valid   (out_valid),
    .out_pass    (out_pass),
    .out_fail    (out_fail)
);

// File: tb/seg_access_checker_bench.sv
module seg_access_checker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_kind = '0;
    logic [15:0] in_sel = '0;
    logic [31:0] in_limit = '0;
    logic [31:0] in_ar = '0;
    logic [63:0] in_base = '0;
    logic        in_v86 = 1'b0;
    logic        in_lm = 1'b0;
    logic [1:0]  in_cs_rpl = '0;
    logic        out_valid, out_pass;
    logic [15:0] out_fail;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    seg_access_checker u_seg_access_checker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
        .in_sel(in_sel), .in_limit(in_limit), .in_ar(in_ar), .in_base(in_base),
        .in_v86(in_v86), .in_lm(in_lm), .in_cs_rpl(in_cs_rpl),
        .out_valid(out_valid), .out_pass(out_pass), .out_fail(out_fail)
    );

    // Expected failure vector, written from the requirement list.
    function automatic logic [15:0] model(input logic [2:0] k, input logic [15:0] s,
        input logic [31:0] lim, input logic [31:0] ar, input logic [63:0] b,
        input logic v, input logic m, input logic [1:0] crpl);
        logic [15:0] f = '0;
        logic [3:0] t = ar[3:0];
        logic [1:0] d = ar[6:5];
        logic [1:0] r = s[1:0];
        logic u = !ar[16];
        logic full, canon, vk;
        if (k > 3'd5) return 16'h8000;                                    // R4
        full  = (k == 0) || (k == 4) || u;
        vk    = v && (k <= 3);
        canon = (b[63:47] == 17'h1FFFF) || (b[63:47] == 17'h0);
        case (k)
            3'd0: begin
                f[1] = !t[0] || (v ? (t != 3) : !t[3]);                   // R6
                f[2] = !ar[4];                                            // R7
                f[3] = (t inside {[8:11]} && d != r) || (t >= 13 && d > r);
                f[6] = ar[14] && (v || (m && ar[13]));                    // R10
                f[14] = (b[63:32] != 0);                                  // R13
            end
            3'd1: begin
                f[1] = (u && !(t == 3 || t == 7)) || (v && t != 3);
                f[2] = u && !ar[4];
                f[3] = !v && d != r;                                      // R8
                f[10] = !v && r != crpl;
                f[6] = v && ar[14];
                f[14] = u && (b[63:32] != 0);
            end
            3'd2, 3'd3: begin
                f[1] = (u && (!t[0] || (t[3] && !t[1]))) || (v && t != 3);
                f[2] = u && !ar[4];
                f[3] = !v && u && t <= 11 && d < r;
                f[6] = v && ar[14];
                if (k == 3'd2) f[14] = u && (b[63:32] != 0);
                else           f[13] = !canon;
            end
            3'd4: begin
                f[1] = m ? (t != 11) : !(t == 3 || t == 11);
                f[2] = ar[4];
                f[9] = s[2];
                f[13] = !canon;
            end
            default: begin
                f[1] = u && t != 2;
                f[2] = u && ar[4];
                f[9] = u && s[2];
                f[13] = u && !canon;
            end
        endcase
        f[0] = (k == 4 && !u) || (vk && !u);                              // R5
        if (vk && d != 3) f[3] = 1'b1;
        f[4] = full && !ar[7];                                            // R9
        f[5] = full && ar[11:8] != 0;
        f[8] = (k == 0 || k == 4) && ar[31:17] != 0;
        f[7] = full && ((ar[15] && (lim[11:0] != 12'hFFF || v))           // R11
                        || (!ar[15] && lim[31:20] != 0));
        f[11] = vk && b != {44'h0, s, 4'h0};                              // R12
        f[12] = vk && lim != 32'h0000FFFF;
        return f;
    endfunction

    function automatic string req_of(input int bitn);
        case (bitn)
            0: return "R5";   1: return "R6";   2: return "R7";
            3, 10: return "R8";
            4, 5, 8: return "R9";
            6: return "R10";  7: return "R11";
            11, 12: return "R12";
            15: return "R4";
            default: return "R13";
        endcase
    endfunction

    task automatic check_result(input logic [15:0] exp_f, input string tag);
        checks++;
        if (out_fail !== exp_f || out_pass !== (exp_f == 0) || out_valid !== 1'b1) begin
            errors++;
            if (out_fail !== exp_f) begin
                for (int i = 0; i < 16; i++)
                    if (out_fail[i] !== exp_f[i]) begin
                        $display("FAIL %s %s bit %0d: fail=%h expected %h", req_of(i), tag,
                                 i, out_fail, exp_f);
                        break;
                    end
            end else
                $display("FAIL R3/R2 %s: pass=%b valid=%b expected pass=%b valid=1",
                         tag, out_pass, out_valid, exp_f == 0);
        end
    endtask

    task automatic drive(input logic [2:0] k, input logic [15:0] s, input logic [31:0] lim,
                         input logic [31:0] ar, input logic [63:0] b, input logic v,
                         input logic m, input logic [1:0] crpl);
        in_valid = 1'b1; in_kind = k; in_sel = s; in_limit = lim; in_ar = ar;
        in_base = b; in_v86 = v; in_lm = m; in_cs_rpl = crpl;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] pend_exp;
        logic        pend;
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R1: reset values
        checks++;
        if (out_valid !== 0 || out_pass !== 0 || out_fail !== 0) begin
            errors++;
            $display("FAIL R1 reset: valid=%b pass=%b fail=%h expected 0 0 0000",
                     out_valid, out_pass, out_fail);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R2: clean code segment passes one cycle later
        drive(3'd0, 16'h0010, 32'hFFFFFFFF, 32'h0000A09B, 64'h0, 1'b0, 1'b0, 2'd0);
        @(negedge clk);
        check_result(16'h0000, "R3 clean code");
        // R12: virtual-8086 data segment consistent with its selector
        drive(3'd2, 16'h1234, 32'h0000FFFF, 32'h000000F3, 64'h12340, 1'b1, 1'b0, 2'd3);
        @(negedge clk);
        check_result(16'h0000, "R12 v86 data");
        // R4: illegal kind
        drive(3'd7, 16'hFFFF, 32'h0, 32'hFFFFFFFF, 64'h8000_0000_0000_0000, 1'b1, 1'b1, 2'd1);
        @(negedge clk);
        check_result(16'h8000, "R4 kind 7");
        // R2: drop valid, change inputs, result held and out_valid low
        held = out_fail;
        in_valid = 1'b0; in_kind = 3'd4; in_ar = 32'h0001_0000;
        @(negedge clk);
        checks++;
        if (out_valid !== 0 || out_fail !== held || out_pass !== 0) begin
            errors++;
            $display("FAIL R2 idle hold: valid=%b fail=%h expected valid=0 fail=%h",
                     out_valid, out_fail, held);
        end
        @(negedge clk);
        // R5: unusable task register
        drive(3'd4, 16'h0040, 32'h00000067, 32'h0001008B, 64'h0, 1'b0, 1'b0, 2'd0);
        @(negedge clk);
        check_result(model(3'd4, 16'h0040, 32'h67, 32'h0001008B, 64'h0, 0, 0, 0),
                     "R5 unusable task");

        // Sweep, one request per cycle, checked the following cycle.
        pend = 1'b0;
        pend_exp = '0;
        for (int k = 0; k < 8; k++)
            for (int md = 0; md < 4; md++)
                for (int t = 0; t < 16; t++)
                    for (int ms = 0; ms < 64; ms++) begin
                        logic [31:0] h, ar, lim;
                        logic [63:0] b;
                        logic [15:0] s;
                        logic [1:0]  crpl;
                        h = ((k * 4096 + md * 1024 + t * 64 + ms + 1) * 32'h9E3779B1);
                        h = h ^ (h >> 15);
                        s = {h[31:19], h[4], h[1:0]};
                        crpl = h[3:2];
                        ar = '0;
                        ar[3:0] = 4'(t);
                        ar[4] = ms[0];
                        ar[7] = ms[1];
                        ar[16] = ms[2];
                        ar[6:5] = 2'(ms >> 3);
                        ar[15] = ms[5];
                        ar[13] = h[5];
                        ar[14] = h[6];
                        ar[9] = h[7] & h[8];
                        ar[22] = h[9] & h[10];
                        ar[12] = h[11];
                        case (h[13:12])
                            2'd0: lim = 32'h0000FFFF;
                            2'd1: lim = 32'hFFFFFFFF;
                            2'd2: lim = 32'h000FFFFF;
                            default: lim = 32'h00100FFF;
                        endcase
                        case (h[15:14])
                            2'd0: b = {44'h0, s, 4'h0};
                            2'd1: b = 64'hFFFF_8000_0000_1000;
                            2'd2: b = 64'h0000_8000_0000_0000;
                            default: b = 64'h0000_0001_0000_0000;
                        endcase
                        if (k == 2 && md == 0 && t == 3 && ms == 27) begin
                            // usable plain data, 0x3 type, DPL 3, S=1, P=1, G=0: likely pass
                            b = 64'h0;
                        end
                        drive(3'(k), s, lim, ar, b, md[0], md[1], crpl);
                        @(negedge clk);
                        if (pend) check_result(pend_exp, "sweep");
                        pend = 1'b0;
                        check_result(model(3'(k), s, lim, ar, b, md[0], md[1], crpl),
                                     "sweep R6 R7 R8 R9 R10 R11 R13");
                    end
        in_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2 after sweep: valid=%b expected 0", out_valid);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end

endmodule